// File: doc/BRIEF.md
# DMA Controller Channel Register Front End

This block is the shared control and status register file of a DMA controller with up to 64 channels. It keeps, for every channel, a hardware request enable bit, an error interrupt enable bit, an interrupt flag, an error flag and a done flag. It also keeps a global control word, one latched error status word and a priority byte per channel. The channel engines report completions on a per-channel event vector and report faults on a single error report port. The block drives one combined interrupt line, the request enable vector and a one-cycle start pulse per channel. Moving data is not part of this block.

Software reaches the block through a plain synchronous register port. Reads are combinational from the byte address, and a write takes effect at the clock edge that samples it. Each per-channel state is held as a pair of 32-bit words. The high word covers channels 63..32 on bits 31..0, and the low word covers channels 31..0. Software can write whole words, or it can change one channel by writing the channel number to a dedicated strobe register, with no read-modify-write.

Top module: `dmac_csr`

## Requirements
- R1: After reset every channel vector, the control word and the error status word read zero, the irq, req_en and start_pulse outputs are low, and priority byte n holds the value n.
- R2: The control word at 0x000 keeps only bits 31, 3 and 2 of a write, and every other bit of it reads zero.
- R3: A write of channel number c (taken from wdata bits 5:0) to 0x040 sets request enable bit c. The same write to 0x044 clears that bit. The req_en output shows the enable bits.
- R4: A write of c to 0x048 sets error interrupt enable bit c, and a write of c to 0x04C clears it.
- R5: A high evt_done bit sets the interrupt flag and the done flag of its channel. A write of c to 0x050 clears interrupt flag c, and a write of c to 0x05C clears done flag c. When a clear and an event hit the same flag in the same cycle, the flag stays set.
- R6: The interrupt words (0x018 high, 0x01C low) and the error flag words (0x020 high, 0x024 low) are write-one-to-clear: a 1 bit clears its flag, and a 0 bit leaves its flag unchanged.
- R7: A high err_report sets the error flag of err_chan. If the error status word (0x004) is not valid, the same report loads it as follows: bit 31 = 1, bits 13:8 = err_chan, bit 15 = err_kind[9], bit 14 = err_kind[8], bits 7:0 = err_kind[7:0], all other bits 0.
- R8: While the error status word is valid, new reports still set their channel flags but leave the word unchanged. A write of c to 0x054 clears error flag c and also clears the whole error status word. A word-wide clear of the error flags does not clear the status word.
- R9: irq is high when any interrupt flag is set, or when some channel has both its error flag and its error interrupt enable set.
- R10: A write of c to 0x058 drives start_pulse bit c high for exactly the one cycle after the write edge.
- R11: Each channel vector is read as two words: the high word at the lower address holds channels 63..32, and the low word at the next address holds channels 31..0. Channel 32+k is at bit k of the high word.
- R12: The hardware request status words (0x028 high, 0x02C low) show the hw_req input.
- R13: Priority bytes start at 0x100. The byte of channel n is at bits 8*(n%4)+7 : 8*(n%4) of the word at 0x100 + 4*(n/4), and these words can be read and written.
- R14: A whole-word write to the request enable words (0x008/0x00C) or to the error interrupt enable words (0x010/0x014) replaces those 32 channel bits. The done words are read at 0x030/0x034.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | AW | Byte address; a write with bits 1:0 non-zero is dropped |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| hw_req | input | NCH | Live hardware request lines |
| evt_done | input | NCH | Per-channel completion events |
| err_report | input | 1 | One error report in this cycle |
| err_chan | input | CW | Channel of the error report |
| err_kind | input | 10 | Error type bits of the report |
| req_en | output | NCH | Request enable bits |
| start_pulse | output | NCH | One-cycle start pulses |
| irq | output | 1 | Combined interrupt |

## Verification
Almost every internal flag can be read directly at a register address. A lost or misrouted set or clear therefore shows up on bus_rdata on the first read after the write edge. If the high and low words are swapped, or the channel index is decoded wrongly, the bit appears in the wrong word or at the wrong position. A wrong error latch shows up in the status word value, either while it is held or after it has been cleared. An error in the interrupt term shows on irq in the same cycle that the flags change. An error in the start path shows on start_pulse in the single cycle after the write.

// File: rtl/dmac_csr.sv
module dmac_csr #(
  parameter int NCH = 64,
  parameter int AW  = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NCH-1:0]         hw_req,
  input  logic [NCH-1:0]         evt_done,
  input  logic                   err_report,
  input  logic [$clog2(NCH)-1:0] err_chan,
  input  logic [9:0]             err_kind,
  output logic [NCH-1:0]         req_en,
  output logic [NCH-1:0]         start_pulse,
  output logic                   irq
);
  localparam int CW  = $clog2(NCH);
  localparam int WW  = AW - 2;
  localparam int NPW = NCH / 4;
  localparam int PIW = (NPW > 1) ? $clog2(NPW) : 1;
  localparam logic [63:0] CHMASK = (NCH >= 64) ? {64{1'b1}} : ((64'd1 << NCH) - 64'd1);
  localparam logic [31:0] CTRL_MASK = 32'h8000_000C;

  localparam logic [WW-1:0] A_CTRL  = WW'(8'h00), A_ESTAT = WW'(8'h01);
  localparam logic [WW-1:0] A_REQH  = WW'(8'h02), A_REQL  = WW'(8'h03);
  localparam logic [WW-1:0] A_EIEH  = WW'(8'h04), A_EIEL  = WW'(8'h05);
  localparam logic [WW-1:0] A_INTH  = WW'(8'h06), A_INTL  = WW'(8'h07);
  localparam logic [WW-1:0] A_ERRH  = WW'(8'h08), A_ERRL  = WW'(8'h09);
  localparam logic [WW-1:0] A_HRSH  = WW'(8'h0A), A_HRSL  = WW'(8'h0B);
  localparam logic [WW-1:0] A_DONH  = WW'(8'h0C), A_DONL  = WW'(8'h0D);
  localparam logic [WW-1:0] A_SREQ  = WW'(8'h10), A_CREQ  = WW'(8'h11);
  localparam logic [WW-1:0] A_SEIE  = WW'(8'h12), A_CEIE  = WW'(8'h13);
  localparam logic [WW-1:0] A_CINT  = WW'(8'h14), A_CERR  = WW'(8'h15);
  localparam logic [WW-1:0] A_SSTRT = WW'(8'h16), A_CDONE = WW'(8'h17);
  localparam logic [WW-1:0] A_PRIO  = WW'(8'h40);

  logic [31:0] ctrl, estat;
  logic [63:0] reqen, eie, intf, errf, donef, startq;
  logic [63:0] reqen_n, eie_n, intf_n, errf_n, donef_n;
  logic [8*NCH-1:0] prio;

  logic [WW-1:0] wa, pword;
  logic          wr, prio_hit;
  logic [CW-1:0] idx;
  logic [63:0]   idx_oh, err_oh, done64, hrs64;

  assign wa       = bus_addr[AW-1:2];
  assign wr       = bus_we && (bus_addr[1:0] == 2'b00);
  assign idx      = bus_wdata[CW-1:0];
  assign idx_oh   = CHMASK & (64'd1 << idx);
  assign err_oh   = err_report ? (CHMASK & (64'd1 << err_chan)) : 64'd0;
  assign done64   = 64'(evt_done);
  assign hrs64    = 64'(hw_req);
  assign pword    = wa - A_PRIO;
  assign prio_hit = (wa >= A_PRIO) && (pword < WW'(NPW));

  logic s_req, c_req, s_eie, c_eie, c_int, c_err, s_strt, c_done;
  assign s_req  = wr && (wa == A_SREQ);
  assign c_req  = wr && (wa == A_CREQ);
  assign s_eie  = wr && (wa == A_SEIE);
  assign c_eie  = wr && (wa == A_CEIE);
  assign c_int  = wr && (wa == A_CINT);
  assign c_err  = wr && (wa == A_CERR);
  assign s_strt = wr && (wa == A_SSTRT);
  assign c_done = wr && (wa == A_CDONE);

  always_comb begin
    reqen_n = reqen;
    if (wr && wa == A_REQH) reqen_n[63:32] = bus_wdata;
    if (wr && wa == A_REQL) reqen_n[31:0]  = bus_wdata;
    if (s_req) reqen_n = reqen_n | idx_oh;
    if (c_req) reqen_n = reqen_n & ~idx_oh;
    reqen_n = reqen_n & CHMASK;

    eie_n = eie;
    if (wr && wa == A_EIEH) eie_n[63:32] = bus_wdata;
    if (wr && wa == A_EIEL) eie_n[31:0]  = bus_wdata;
    if (s_eie) eie_n = eie_n | idx_oh;
    if (c_eie) eie_n = eie_n & ~idx_oh;
    eie_n = eie_n & CHMASK;

    intf_n = intf;
    if (wr && wa == A_INTH) intf_n[63:32] = intf_n[63:32] & ~bus_wdata;
    if (wr && wa == A_INTL) intf_n[31:0]  = intf_n[31:0] & ~bus_wdata;
    if (c_int) intf_n = intf_n & ~idx_oh;
    intf_n = (intf_n | done64) & CHMASK;

    errf_n = errf;
    if (wr && wa == A_ERRH) errf_n[63:32] = errf_n[63:32] & ~bus_wdata;
    if (wr && wa == A_ERRL) errf_n[31:0]  = errf_n[31:0] & ~bus_wdata;
    if (c_err) errf_n = errf_n & ~idx_oh;
    errf_n = (errf_n | err_oh) & CHMASK;

    donef_n = donef;
    if (c_done) donef_n = donef_n & ~idx_oh;
    donef_n = (donef_n | done64) & CHMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      estat  <= '0;
      reqen  <= '0;
      eie    <= '0;
      intf   <= '0;
      errf   <= '0;
      donef  <= '0;
      startq <= '0;
      for (int c = 0; c < NCH; c++) prio[8*c +: 8] <= 8'(c);
    end else begin
      reqen  <= reqen_n;
      eie    <= eie_n;
      intf   <= intf_n;
      errf   <= errf_n;
      donef  <= donef_n;
      startq <= s_strt ? idx_oh : 64'd0;
      if (wr && wa == A_CTRL) ctrl <= bus_wdata & CTRL_MASK;
      if (err_report && (!estat[31] || c_err))
        estat <= {1'b1, 15'd0, err_kind[9:8], 6'(err_chan), err_kind[7:0]};
      else if (c_err)
        estat <= '0;
      if (wr && prio_hit) prio[32*pword[PIW-1:0] +: 32] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (wa)
      A_CTRL:  bus_rdata = ctrl;
      A_ESTAT: bus_rdata = estat;
      A_REQH:  bus_rdata = reqen[63:32];
      A_REQL:  bus_rdata = reqen[31:0];
      A_EIEH:  bus_rdata = eie[63:32];
      A_EIEL:  bus_rdata = eie[31:0];
      A_INTH:  bus_rdata = intf[63:32];
      A_INTL:  bus_rdata = intf[31:0];
      A_ERRH:  bus_rdata = errf[63:32];
      A_ERRL:  bus_rdata = errf[31:0];
      A_HRSH:  bus_rdata = hrs64[63:32];
      A_HRSL:  bus_rdata = hrs64[31:0];
      A_DONH:  bus_rdata = donef[63:32];
      A_DONL:  bus_rdata = donef[31:0];
      default: if (prio_hit) bus_rdata = prio[32*pword[PIW-1:0] +: 32];
    endcase
  end

  assign req_en      = reqen[NCH-1:0];
  assign start_pulse = startq[NCH-1:0];
  assign irq         = (|intf) || (|(errf & eie));

  a_r10_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));
  a_r10_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[1:0] == 2'b00 && wa == A_SSTRT) |=> start_pulse[$past(bus_wdata[CW-1:0])]);
  a_r8_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (estat[31] && !c_err) |=> $stable(estat));
  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_report |=> errf[$past(err_chan)]);
  a_r5_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_done) |=> ((intf[NCH-1:0] & $past(evt_done)) == $past(evt_done)));
  a_r9_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|intf) |-> irq);
endmodule

// File: tb/dmac_csr_tb.sv
module dmac_csr_tb;
  localparam int NCH = 64;
  localparam int AW  = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] hw_req = '0, evt_done = '0, req_en, start_pulse;
  logic err_report = 1'b0;
  logic [5:0] err_chan = '0;
  logic [9:0] err_kind = '0;
  logic irq;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dmac_csr #(.NCH(NCH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_req(hw_req),
    .evt_done(evt_done), .err_report(err_report), .err_chan(err_chan),
    .err_kind(err_kind), .req_en(req_en), .start_pulse(start_pulse), .irq(irq));

  // op 0 = write, 1 = read and compare; {op, addr, data}
  localparam int NV = 25;
  localparam logic [42:0] VEC [NV] = '{
    {1'b0, 10'h000, 32'hFFFF_FFFF},  // R2
    {1'b1, 10'h000, 32'h8000_000C},
    {1'b0, 10'h000, 32'h0000_0004},
    {1'b1, 10'h000, 32'h0000_0004},
    {1'b0, 10'h040, 32'h0000_0005},  // R3 set ch5
    {1'b0, 10'h040, 32'h0000_0028},  // R3 set ch40
    {1'b1, 10'h00C, 32'h0000_0020},  // R11 low word
    {1'b1, 10'h008, 32'h0000_0100},  // R11 high word
    {1'b0, 10'h044, 32'h0000_0005},  // R3 clear ch5
    {1'b1, 10'h00C, 32'h0000_0000},
    {1'b0, 10'h00C, 32'hA5A5_0000},  // R14
    {1'b1, 10'h00C, 32'hA5A5_0000},
    {1'b0, 10'h044, 32'h0000_0010},  // R3 clear ch16
    {1'b1, 10'h00C, 32'hA5A4_0000},
    {1'b0, 10'h010, 32'h0000_00F0},  // R14
    {1'b1, 10'h010, 32'h0000_00F0},
    {1'b0, 10'h048, 32'h0000_0003},  // R4 set ch3
    {1'b1, 10'h014, 32'h0000_0008},
    {1'b0, 10'h04C, 32'h0000_0024},  // R4 clear ch36
    {1'b1, 10'h010, 32'h0000_00E0},
    {1'b1, 10'h100, 32'h0302_0100},  // R13
    {1'b0, 10'h104, 32'h1122_3344},
    {1'b1, 10'h104, 32'h1122_3344},
    {1'b1, 10'h108, 32'h0B0A_0908},
    {1'b1, 10'h13C, 32'h3F3E_3D3C}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic pulse_done(input logic [NCH-1:0] v);
    @(negedge clk); evt_done = v;
    @(negedge clk); evt_done = '0;
  endtask

  task automatic report(input logic [5:0] c, input logic [9:0] k);
    @(negedge clk); err_report = 1'b1; err_chan = c; err_kind = k;
    @(negedge clk); err_report = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 req_en", 64'(req_en), 64'd0);
    check("R1 start", 64'(start_pulse), 64'd0);
    rd_chk("R1 ctrl", 10'h000, 32'd0);
    rd_chk("R1 estat", 10'h004, 32'd0);
    rd_chk("R1 intl", 10'h01C, 32'd0);
    rd_chk("R1 prio", 10'h11C, 32'h1F1E_1D1C);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) rd_chk($sformatf("table %0d", i), VEC[i][41:32], VEC[i][31:0]);
      else wr(VEC[i][41:32], VEC[i][31:0]);
    end
    check("R3 req_en port", 64'(req_en), 64'h0000_0100_A5A4_0000);

    // R12
    hw_req = 64'hDEAD_0000_0000_BEEF;
    rd_chk("R12 high", 10'h028, 32'hDEAD_0000);
    rd_chk("R12 low", 10'h02C, 32'h0000_BEEF);

    // R5 / R9 / R6
    pulse_done(64'h0000_0008_0000_0008);
    rd_chk("R5 int low", 10'h01C, 32'h8);
    rd_chk("R5 int high", 10'h018, 32'h8);
    rd_chk("R5 done low", 10'h034, 32'h8);
    check("R9 irq on int", 64'(irq), 64'd1);
    wr(10'h050, 32'd3);
    rd_chk("R5 clear int", 10'h01C, 32'h0);
    check("R9 irq still", 64'(irq), 64'd1);
    wr(10'h018, 32'h8);
    rd_chk("R6 w1c high", 10'h018, 32'h0);
    check("R9 irq drop", 64'(irq), 64'd0);
    wr(10'h05C, 32'd35);
    rd_chk("R5 clear done", 10'h030, 32'h0);
    rd_chk("R5 done kept", 10'h034, 32'h8);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 10'h050; bus_wdata = 32'd7; evt_done = 64'h80;
    @(negedge clk);
    bus_we = 1'b0; evt_done = '0;
    rd_chk("R5 set wins", 10'h01C, 32'h80);
    wr(10'h01C, 32'h0);
    rd_chk("R6 zero keeps", 10'h01C, 32'h80);
    wr(10'h01C, 32'hFFFF_FFFF);
    rd_chk("R6 all ones", 10'h01C, 32'h0);

    // R7 / R8 / R9
    report(6'd33, 10'h305);
    rd_chk("R7 err high", 10'h020, 32'h2);
    rd_chk("R7 status", 10'h004, 32'h8000_E105);
    check("R9 masked", 64'(irq), 64'd0);
    wr(10'h048, 32'd33);
    check("R9 enabled", 64'(irq), 64'd1);
    report(6'd2, 10'h080);
    rd_chk("R8 flag", 10'h024, 32'h4);
    rd_chk("R8 held", 10'h004, 32'h8000_E105);
    wr(10'h054, 32'd33);
    rd_chk("R8 clr flag", 10'h020, 32'h0);
    rd_chk("R8 clr status", 10'h004, 32'h0);
    check("R9 irq off", 64'(irq), 64'd0);
    report(6'd2, 10'h001);
    rd_chk("R7 relatch", 10'h004, 32'h8000_0201);
    wr(10'h024, 32'hFFFF_FFFF);
    rd_chk("R6 err w1c", 10'h024, 32'h0);
    rd_chk("R8 w1c keeps", 10'h004, 32'h8000_0201);
    wr(10'h054, 32'd2);
    rd_chk("R8 cleared", 10'h004, 32'h0);

    // R10
    wr(10'h058, 32'd12);
    check("R10 pulse", 64'(start_pulse), 64'd1 << 12);
    @(negedge clk);
    check("R10 one cycle", 64'(start_pulse), 64'd0);
    wr(10'h058, 32'd63);
    check("R10 top", 64'(start_pulse), 64'd1 << 63);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule